// File: doc/BRIEF.md
# Out-of-Order Instruction Window Scheduler

This block sits between instruction decode and the execution units. Decode writes up to two decoded instructions per cycle into an eight-entry window for as long as the window has room. Each stored entry carries its execution unit type, its destination register, two source register tags and a ready flag for each source. Two completion broadcast ports carry the destination tags of results being written back. Every stored source whose tag matches a broadcast becomes ready.

Each execution unit has its own issue port. In any cycle where a unit reports itself free, the window picks one stored entry of that unit's type and presents it on that port. The entry must have both sources ready, and no older entry still in the window may write the same destination. Program order plays no part in the choice, so an independent younger instruction can pass an older one that is stalled. When several entries qualify for the same unit, the one inserted earliest wins. An issued entry frees its slot at the next clock edge.

Occupancy is tracked by a small state machine with three states. `WIN_EMPTY` means no valid entry, `WIN_PART` means some but not all entries valid, and `WIN_FULL` means every entry valid. Its transitions are FILL (`WIN_EMPTY` to `WIN_PART`), TOP_OFF (`WIN_PART` to `WIN_FULL`), DRAIN (`WIN_FULL` to `WIN_PART`) and EMPTY_OUT (`WIN_PART` to `WIN_EMPTY`). The direct jumps `WIN_EMPTY`→`WIN_FULL` and `WIN_FULL`→`WIN_EMPTY` exist only for parameter sets where one cycle can fill or empty the whole window. The next state comes from the occupancy count after this cycle's enqueues and issues.

Top module: `ow_window`

## Requirements
- R1: After reset the window holds no entries, `iss_valid` is all zero, `enq_ready` is 2'b11 and `win_full` is 0.
- R2: Lane 0 is accepted when `enq_valid[0]` and `enq_ready[0]` are both high, and lane 1 likewise with its own bits. `enq_ready[0]` is high when at least one entry is free and `enq_ready[1]` when at least two are free. Free entries are counted at the start of the cycle, so entries issuing in the same cycle do not count as free. When both lanes are accepted together, lane 0 is the older.
- R3: `win_full` is high exactly when all 8 entries are valid.
- R4: An entry written at a clock edge can appear on an issue port in the cycle that directly follows that edge.
- R5: Issue port u (unit type value u, for u = 0, 1, 2) presents an entry only while `unit_free[u]` is high. The entry must have unit type u and both source ready flags set. Each port presents at most one entry per cycle, and the presented entry leaves the window at the next edge.
- R6: Selection ignores program order. A ready younger entry issues while an older entry of the same unit type is still waiting on a source.
- R7: Among the entries eligible for one unit, the one inserted earliest is presented.
- R8: A valid `bc_valid[p]` with tag `bc_tag[p]` sets the ready flag of every stored source whose tag equals it. Both broadcast ports act in the same cycle, and the woken entry can issue from the next cycle.
- R9: An instruction enqueued in the same cycle as a broadcast that matches one of its sources stores that source as ready.
- R10: An entry does not issue while an older valid entry in the window has the same destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 2 | Per-lane enqueue request |
| enq_ut | input | 2x2 | Per-lane unit type (0..2) |
| enq_dst | input | 2x5 | Per-lane destination register |
| enq_src1 | input | 2x5 | Per-lane first source tag |
| enq_src2 | input | 2x5 | Per-lane second source tag |
| enq_rdy1 | input | 2 | Per-lane first source already available |
| enq_rdy2 | input | 2 | Per-lane second source already available |
| enq_ready | output | 2 | Per-lane acceptance, from free space |
| win_full | output | 1 | All entries valid |
| unit_free | input | 3 | Unit can take an instruction this cycle |
| iss_valid | output | 3 | Entry presented on unit port |
| iss_dst | output | 3x5 | Destination of presented entry |
| iss_src1 | output | 3x5 | First source tag of presented entry |
| iss_src2 | output | 3x5 | Second source tag of presented entry |
| bc_valid | input | 2 | Completion broadcast valid |
| bc_tag | input | 2x5 | Completion broadcast destination tag |

## Verification
The assertions assume that decode never asserts a lane's `enq_valid` unless its unit type lies in 0..2. They also assume that each unit accepts the presented entry in the cycle it is shown, so a presentation counts as an issue. The stimulus draws unit types only from 0..2 and always treats a presentation on a free unit as taken. Destination and source tags are drawn from a small range so that write-after-write conflicts, broadcast matches and same-cycle captures happen often. Broadcast tags cover the same range, so a stalled source is eventually woken and the window keeps draining.

// File: rtl/ow_pkg.sv
package ow_pkg;
    localparam int OW_ENTRIES = 8;
    localparam int OW_REG_W   = 5;
    localparam int OW_UNITS   = 3;
    localparam int OW_LANES   = 2;
    localparam int OW_PORTS   = 2;
    localparam int OW_UT_W    = (OW_UNITS > 1) ? $clog2(OW_UNITS) : 1;

    typedef enum logic [1:0] {
        WIN_EMPTY = 2'd0,
        WIN_PART  = 2'd1,
        WIN_FULL  = 2'd2
    } win_state_e;

    typedef struct packed {
        logic                vld;
        logic [OW_UT_W-1:0]  ut;
        logic [OW_REG_W-1:0] dst;
        logic [OW_REG_W-1:0] s1;
        logic [OW_REG_W-1:0] s2;
        logic                r1;
        logic                r2;
    } ow_entry_t;
endpackage

// File: rtl/ow_slot_alloc.sv
module ow_slot_alloc #(
    parameter int N = 8
) (
    input  logic [N-1:0] vld,
    output logic [N-1:0] first_oh,
    output logic [N-1:0] second_oh
);
    always_comb begin
        int seen;
        seen      = 0;
        first_oh  = '0;
        second_oh = '0;
        for (int i = 0; i < N; i++) begin
            if (!vld[i]) begin
                if (seen == 0) first_oh[i] = 1'b1;
                else if (seen == 1) second_oh[i] = 1'b1;
                seen = seen + 1;
            end
        end
    end
endmodule

// File: rtl/ow_fill_fsm.sv
module ow_fill_fsm #(
    parameter int N     = 8,
    parameter int ISS_N = 3,
    localparam int CNT_W = $clog2(N + 1),
    localparam int ISS_W = $clog2(ISS_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       n_enq,
    input  logic [ISS_W-1:0] n_iss,
    output logic [CNT_W-1:0] occ,
    output logic [1:0]       lane_ready,
    output logic             full
);
    import ow_pkg::*;

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] occ_d;
    logic [CNT_W-1:0] free_now;

    assign occ_d    = occ + CNT_W'(n_enq) - CNT_W'(n_iss);
    assign free_now = CNT_W'(N) - occ;

    always_comb begin
        if (occ_d == '0)             state_d = WIN_EMPTY;
        else if (occ_d == CNT_W'(N)) state_d = WIN_FULL;
        else                         state_d = WIN_PART;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_EMPTY;
            occ     <= '0;
        end else begin
            state_q <= state_d;
            occ     <= occ_d;
        end
    end

    always_comb begin
        lane_ready = 2'b00;
        full       = 1'b0;
        unique case (state_q)
            WIN_EMPTY: lane_ready = 2'b11;
            WIN_PART:  lane_ready = {free_now >= CNT_W'(2), 1'b1};
            WIN_FULL:  full = 1'b1;
            default:   lane_ready = 2'b00;
        endcase
    end
endmodule

// File: rtl/ow_pick.sv
module ow_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][N-1:0]  older,
    output logic [N-1:0]         grant
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && cand[j] && older[j][i]) beaten = 1'b1;
            end
            grant[i] = cand[i] && !beaten;
        end
    end
endmodule

// File: rtl/ow_window.sv
module ow_window #(
    parameter int N_ENTRIES = ow_pkg::OW_ENTRIES,
    localparam int REG_W = ow_pkg::OW_REG_W,
    localparam int UNITS = ow_pkg::OW_UNITS,
    localparam int UT_W  = ow_pkg::OW_UT_W,
    localparam int LANES = ow_pkg::OW_LANES,
    localparam int PORTS = ow_pkg::OW_PORTS,
    localparam int CNT_W = $clog2(N_ENTRIES + 1),
    localparam int ISS_W = $clog2(UNITS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             enq_valid,
    input  logic [LANES-1:0][UT_W-1:0]   enq_ut,
    input  logic [LANES-1:0][REG_W-1:0]  enq_dst,
    input  logic [LANES-1:0][REG_W-1:0]  enq_src1,
    input  logic [LANES-1:0][REG_W-1:0]  enq_src2,
    input  logic [LANES-1:0]             enq_rdy1,
    input  logic [LANES-1:0]             enq_rdy2,
    output logic [LANES-1:0]             enq_ready,
    output logic                         win_full,
    input  logic [UNITS-1:0]             unit_free,
    output logic [UNITS-1:0]             iss_valid,
    output logic [UNITS-1:0][REG_W-1:0]  iss_dst,
    output logic [UNITS-1:0][REG_W-1:0]  iss_src1,
    output logic [UNITS-1:0][REG_W-1:0]  iss_src2,
    input  logic [PORTS-1:0]             bc_valid,
    input  logic [PORTS-1:0][REG_W-1:0]  bc_tag
);
    import ow_pkg::*;

    ow_entry_t                          ent_q [N_ENTRIES];
    logic [N_ENTRIES-1:0][N_ENTRIES-1:0] older_q;
    logic [N_ENTRIES-1:0]               vld_q;
    logic [N_ENTRIES-1:0]               first_oh, second_oh;
    logic [N_ENTRIES-1:0]               wr0, wr1, wr_any;
    logic [LANES-1:0]                   acc;
    ow_entry_t                          new_ent [LANES];
    logic [N_ENTRIES-1:0]               hit1, hit2, waw_blk, elig, iss_any;
    logic [UNITS-1:0][N_ENTRIES-1:0]    cand, grant;
    logic [CNT_W-1:0]                   occ_cnt;
    logic [ISS_W-1:0]                   n_iss;

    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) vld_q[i] = ent_q[i].vld;
    end

    ow_slot_alloc #(.N(N_ENTRIES)) u_alloc (
        .vld       (vld_q),
        .first_oh  (first_oh),
        .second_oh (second_oh)
    );

    assign acc    = enq_valid & enq_ready;
    assign wr0    = acc[0] ? first_oh : '0;
    assign wr1    = acc[1] ? (acc[0] ? second_oh : first_oh) : '0;
    assign wr_any = wr0 | wr1;

    // Broadcast matching for stored sources and for incoming lanes
    always_comb begin
        hit1 = '0;
        hit2 = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            for (int p = 0; p < PORTS; p++) begin
                if (bc_valid[p] && bc_tag[p] == ent_q[i].s1) hit1[i] = 1'b1;
                if (bc_valid[p] && bc_tag[p] == ent_q[i].s2) hit2[i] = 1'b1;
            end
        end
        for (int k = 0; k < LANES; k++) begin
            logic m1, m2;
            m1 = 1'b0;
            m2 = 1'b0;
            for (int p = 0; p < PORTS; p++) begin
                if (bc_valid[p] && bc_tag[p] == enq_src1[k]) m1 = 1'b1;
                if (bc_valid[p] && bc_tag[p] == enq_src2[k]) m2 = 1'b1;
            end
            new_ent[k].vld = 1'b1;
            new_ent[k].ut  = enq_ut[k];
            new_ent[k].dst = enq_dst[k];
            new_ent[k].s1  = enq_src1[k];
            new_ent[k].s2  = enq_src2[k];
            new_ent[k].r1  = enq_rdy1[k] | m1;
            new_ent[k].r2  = enq_rdy2[k] | m2;
        end
    end

    // Write-after-write hold and eligibility
    always_comb begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            waw_blk[i] = 1'b0;
            for (int j = 0; j < N_ENTRIES; j++) begin
                if (j != i && ent_q[j].vld && older_q[j][i] &&
                    ent_q[j].dst == ent_q[i].dst) waw_blk[i] = 1'b1;
            end
            elig[i] = ent_q[i].vld && ent_q[i].r1 && ent_q[i].r2 && !waw_blk[i];
        end
    end

    genvar gu;
    generate
        for (gu = 0; gu < UNITS; gu++) begin : g_unit
            always_comb begin
                for (int i = 0; i < N_ENTRIES; i++) begin
                    cand[gu][i] = elig[i] && unit_free[gu] &&
                                  (ent_q[i].ut == UT_W'(gu));
                end
            end
            ow_pick #(.N(N_ENTRIES)) u_pick (
                .cand  (cand[gu]),
                .older (older_q),
                .grant (grant[gu])
            );
        end
    endgenerate

    always_comb begin
        iss_any  = '0;
        iss_dst  = '0;
        iss_src1 = '0;
        iss_src2 = '0;
        for (int u = 0; u < UNITS; u++) begin
            iss_valid[u] = |grant[u];
            iss_any      = iss_any | grant[u];
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (grant[u][i]) begin
                    iss_dst[u]  = iss_dst[u]  | ent_q[i].dst;
                    iss_src1[u] = iss_src1[u] | ent_q[i].s1;
                    iss_src2[u] = iss_src2[u] | ent_q[i].s2;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (wr0[i])          ent_q[i] <= new_ent[0];
                else if (wr1[i])     ent_q[i] <= new_ent[1];
                else if (iss_any[i]) ent_q[i].vld <= 1'b0;
                else begin
                    if (hit1[i]) ent_q[i].r1 <= 1'b1;
                    if (hit2[i]) ent_q[i].r2 <= 1'b1;
                end
            end
        end
    end

    // Age matrix: older_q[i][j] set means entry i was inserted before entry j
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                for (int j = 0; j < N_ENTRIES; j++) begin
                    if (wr_any[j])
                        older_q[i][j] <= (vld_q[i] && !wr_any[i]) || (wr0[i] && wr1[j]);
                    else if (wr_any[i])
                        older_q[i][j] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        n_iss = '0;
        for (int u = 0; u < UNITS; u++) n_iss = n_iss + ISS_W'(iss_valid[u]);
    end

    ow_fill_fsm #(.N(N_ENTRIES), .ISS_N(UNITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .n_enq      (2'(acc[0]) + 2'(acc[1])),
        .n_iss      (n_iss),
        .occ        (occ_cnt),
        .lane_ready (enq_ready),
        .full       (win_full)
    );
endmodule

// File: rtl/ow_window_chk.sv
module ow_window_chk #(
    parameter int N     = 8,
    parameter int U     = 3,
    parameter int REG_W = 5,
    localparam int CNT_W = $clog2(N + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               enq_ready,
    input logic                     win_full,
    input logic [U-1:0]             unit_free,
    input logic [U-1:0]             iss_valid,
    input logic [U-1:0][REG_W-1:0]  iss_dst,
    input logic [CNT_W-1:0]         occ_cnt,
    input logic [N-1:0]             vld_q
);
    // R3
    full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_full == (occ_cnt == CNT_W'(N)));

    // R2
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_ready[1] |-> enq_ready[0]);

    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt == CNT_W'($countones(vld_q)));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_full |-> (enq_ready == 2'b00));

    genvar a, b;
    generate
        for (a = 0; a < U; a++) begin : g_a
            // R5
            free_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[a] |-> unit_free[a]);
            for (b = a + 1; b < U; b++) begin : g_b
                // R10
                waw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (iss_valid[a] && iss_valid[b]) |-> (iss_dst[a] != iss_dst[b]));
            end
        end
    endgenerate
endmodule

bind ow_window ow_window_chk #(
    .N     (N_ENTRIES),
    .U     (ow_pkg::OW_UNITS),
    .REG_W (ow_pkg::OW_REG_W)
) u_ow_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_ready (enq_ready),
    .win_full  (win_full),
    .unit_free (unit_free),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .occ_cnt   (occ_cnt),
    .vld_q     (vld_q)
);

// File: tb/test_ow_window.sv
module test_ow_window;
    localparam int N  = 8;
    localparam int RW = 5;
    localparam int NU = 3;
    localparam int UW = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         enq_valid;
    logic [1:0][UW-1:0] enq_ut;
    logic [1:0][RW-1:0] enq_dst, enq_src1, enq_src2;
    logic [1:0]         enq_rdy1, enq_rdy2, enq_ready;
    logic               win_full;
    logic [NU-1:0]      unit_free, iss_valid;
    logic [NU-1:0][RW-1:0] iss_dst, iss_src1, iss_src2;
    logic [1:0]         bc_valid;
    logic [1:0][RW-1:0] bc_tag;

    always #5 clk = ~clk;

    ow_window i_ow_window (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ut(enq_ut), .enq_dst(enq_dst),
        .enq_src1(enq_src1), .enq_src2(enq_src2),
        .enq_rdy1(enq_rdy1), .enq_rdy2(enq_rdy2),
        .enq_ready(enq_ready), .win_full(win_full),
        .unit_free(unit_free), .iss_valid(iss_valid),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .bc_valid(bc_valid), .bc_tag(bc_tag)
    );

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    string itag = "R5";

    bit m_v [N];
    int m_ut [N], m_dst [N], m_s1 [N], m_s2 [N], m_seq [N];
    bit m_r1 [N], m_r2 [N];
    int seq_ctr = 0;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < N; i++) if (m_v[i]) c++;
        return c;
    endfunction

    function automatic bit bc_match(input int tag);
        for (int p = 0; p < 2; p++) if (bc_valid[p] && int'(bc_tag[p]) == tag) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int exp_pick(input int u);
        int best = -1;
        if (!unit_free[u]) return -1;
        for (int i = 0; i < N; i++) begin
            bit blk = 0;
            if (!(m_v[i] && m_ut[i] == u && m_r1[i] && m_r2[i])) continue;
            for (int j = 0; j < N; j++)
                if (j != i && m_v[j] && m_seq[j] < m_seq[i] && m_dst[j] == m_dst[i]) blk = 1;
            if (blk) continue;
            if (best < 0 || m_seq[i] < m_seq[best]) best = i;
        end
        return best;
    endfunction

    function automatic int free_slot();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    task automatic clear_inputs();
        enq_valid = '0; enq_ut = '0; enq_dst = '0; enq_src1 = '0; enq_src2 = '0;
        enq_rdy1 = '0; enq_rdy2 = '0; bc_valid = '0; bc_tag = '0;
    endtask

    task automatic lane(input int k, input int ut, input int dst, input int s1,
                        input int s2, input bit r1, input bit r2);
        enq_valid[k] = 1'b1; enq_ut[k] = UW'(ut); enq_dst[k] = RW'(dst);
        enq_src1[k] = RW'(s1); enq_src2[k] = RW'(s2); enq_rdy1[k] = r1; enq_rdy2[k] = r2;
    endtask

    // Called just after the negedge with inputs driven; advances to next negedge
    task automatic step();
        int free, pk [NU];
        bit acc [2];
        #1;
        free = N - m_count();
        chk("R2 lane0 ready", int'(enq_ready[0]), int'(free >= 1));
        chk("R2 lane1 ready", int'(enq_ready[1]), int'(free >= 2));
        chk("R3 full", int'(win_full), int'(free == 0));
        for (int u = 0; u < NU; u++) begin
            pk[u] = exp_pick(u);
            chk({itag, " issue valid"}, int'(iss_valid[u]), int'(pk[u] >= 0));
            if (pk[u] >= 0) begin
                chk({itag, " issue dst"}, int'(iss_dst[u]), m_dst[pk[u]]);
                chk({itag, " issue src1"}, int'(iss_src1[u]), m_s1[pk[u]]);
                chk({itag, " issue src2"}, int'(iss_src2[u]), m_s2[pk[u]]);
            end
        end
        acc[0] = enq_valid[0] && (free >= 1);
        acc[1] = enq_valid[1] && (free >= 2);
        @(posedge clk);
        for (int u = 0; u < NU; u++) if (pk[u] >= 0) m_v[pk[u]] = 0;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && bc_match(m_s1[i])) m_r1[i] = 1;
            if (m_v[i] && bc_match(m_s2[i])) m_r2[i] = 1;
        end
        for (int k = 0; k < 2; k++) begin
            if (acc[k]) begin
                int s = free_slot();
                m_v[s] = 1; m_ut[s] = int'(enq_ut[k]); m_dst[s] = int'(enq_dst[k]);
                m_s1[s] = int'(enq_src1[k]); m_s2[s] = int'(enq_src2[k]);
                m_r1[s] = enq_rdy1[k] | bc_match(int'(enq_src1[k]));
                m_r2[s] = enq_rdy2[k] | bc_match(int'(enq_src2[k]));
                m_seq[s] = seq_ctr++;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        for (int i = 0; i < N; i++) m_v[i] = 0;
        clear_inputs();
        unit_free = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 enq_ready", int'(enq_ready), 3);
        chk("R1 win_full", int'(win_full), 0);
        chk("R1 iss_valid", int'(iss_valid), 0);
        @(negedge clk);

        // R4 / R6: older stalled, younger ready, same unit
        itag = "R4 R6";
        unit_free = '1;
        lane(0, 0, 1, 20, 3, 1'b0, 1'b1);
        lane(1, 0, 2, 4, 5, 1'b1, 1'b1);
        step();
        clear_inputs();
        step();
        step();

        // R9: enqueue with a matching broadcast in the same cycle; R8 wakes stored entry
        itag = "R9 R8";
        lane(0, 1, 6, 21, 7, 1'b0, 1'b1);
        bc_valid = 2'b11; bc_tag[0] = RW'(21); bc_tag[1] = RW'(20);
        step();
        clear_inputs();
        step();
        step();

        // R10: older and younger share destination, older waits on a source
        itag = "R10";
        lane(0, 1, 9, 22, 1, 1'b0, 1'b1);
        lane(1, 2, 9, 2, 3, 1'b1, 1'b1);
        step();
        clear_inputs();
        step();
        step();
        bc_valid = 2'b10; bc_tag[1] = RW'(22);
        step();
        clear_inputs();
        step();
        step();
        step();

        // R7: several ready entries for unit 0 while it is busy, then release it
        itag = "R7";
        unit_free = 3'b110;
        lane(0, 0, 10, 1, 1, 1'b1, 1'b1);
        lane(1, 0, 11, 1, 1, 1'b1, 1'b1);
        step();
        lane(0, 0, 12, 1, 1, 1'b1, 1'b1);
        enq_valid[1] = 1'b0;
        step();
        clear_inputs();
        unit_free = 3'b111;
        repeat (4) step();

        // R2 / R3: fill to full with all units busy, then drain
        itag = "R5 fill";
        unit_free = '0;
        for (int c = 0; c < 6; c++) begin
            lane(0, c % 3, 13 + c, 1, 1, 1'b1, 1'b1);
            lane(1, (c + 1) % 3, 24 + (c % 6), 1, 1, 1'b1, 1'b1);
            step();
        end
        clear_inputs();
        unit_free = '1;
        repeat (6) step();

        // Random phase
        itag = "R5 R8 random";
        for (int c = 0; c < 3000; c++) begin
            clear_inputs();
            for (int k = 0; k < 2; k++) begin
                if ($urandom % 3 != 0)
                    lane(k, $urandom % 3, $urandom % 8, $urandom % 8, $urandom % 8,
                         1'($urandom % 3 == 0), 1'($urandom % 2));
            end
            for (int p = 0; p < 2; p++) begin
                bc_valid[p] = 1'($urandom % 2);
                bc_tag[p] = RW'($urandom % 8);
            end
            unit_free = NU'($urandom);
            step();
        end

        // Drain
        itag = "R5 drain";
        clear_inputs();
        unit_free = '1;
        for (int c = 0; c < 40; c++) begin
            bc_valid = 2'b11;
            bc_tag[0] = RW'((2 * c) % 8);
            bc_tag[1] = RW'((2 * c + 1) % 8);
            step();
        end
        clear_inputs();
        step();
        chk("R3 drained empty", int'(enq_ready), 3);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule